// File: doc/BRIEF.md
# Open-Drain Line Direction Repeater

This block joins two open-drain data lines that live in separate supply domains: one faces a card and one faces a host controller. Neither side has a direction control. When both lines are idle and high, the block watches both of them. The first side whose line is seen to fall becomes the master, and the other side becomes the slave. After a fixed number of clock cycles, the block pulls the slave line low, which copies the master's low level across. When the master lets go, the block releases the slave pull-down. It then drives a short active pull-up on the slave so that the line rises fast. Once that pulse has ended and both lines read high again, the block goes back to idle.

Each side is modelled by three signals: a sampled input level, a pull-down enable and an active pull-up enable. Both inputs pass through two-flop synchronisers before any edge is detected. All delays are whole clock cycles, set by the parameters `EDGE_DLY` and `PU_LEN`. An elaboration check rejects any setting where the repeat delay plus the pull-up pulse do not fit in half of a 1 MHz bit period at the clock rate given by `CLK_KHZ`. The data line and the auxiliary lines can each use one instance. A synchronous `disable_i` input returns the block to idle, for use while the contacts are being shut down.

Top module: `od_line_repeater`

## Requirements
- R1: While reset is asserted, and after it is released with both lines high, all four drive outputs (`card_pd_o`, `card_pu_o`, `host_pd_o`, `host_pu_o`) are 0.
- R2: The first side whose synchronised input falls while the block is idle becomes master. Only the opposite side is ever driven during that transfer.
- R3: A pin that falls between clock edges is detected at the third following edge. The slave pull-down is 1 from edge 3+`EDGE_DLY` (counting the first edge after the fall as edge 1) until the master release takes effect.
- R4: The master side's pull-down and pull-up stay 0 for the whole transfer. At most one of the four drive outputs is 1 at any time.
- R5: If the master pin rises after edge H, the slave pull-down is 0 from edge H+3. The slave pull-up is 1 for exactly `PU_LEN` cycles from edge H+3. This also applies when the release comes before the repeat delay has run out, in which case the pull-down never turns on.
- R6: A low on the slave line, whether caused by the block's own pull-down or by anything else, never starts a new transfer while one is in progress.
- R7: If both synchronised inputs fall in the same cycle, the host side becomes master and the card side is driven.
- R8: No new master is chosen until the pull-up pulse has ended and both synchronised inputs read high. A line that was held low through that recovery does not start a transfer when it is released.
- R9: `disable_i` high at a clock edge makes all drive outputs 0 from that edge on. A line that is still low when `disable_i` drops does not become master.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disable_i | input | 1 | Synchronous force-to-idle |
| card_in_i | input | 1 | Level read on the card-side line |
| card_pd_o | output | 1 | Card-side pull-down enable |
| card_pu_o | output | 1 | Card-side active pull-up enable |
| host_in_i | input | 1 | Level read on the host-side line |
| host_pd_o | output | 1 | Host-side pull-down enable |
| host_pu_o | output | 1 | Host-side active pull-up enable |

## Verification
A wrong internal state shows up at the drive enables within one cycle of the edge where it matters:
- A master choice that is wrong, or a lockout that fails, appears as a pull-down on the side that started the transfer. Because the slave line is looped back through the bench's line model, this shows within a few cycles.
- A repeat counter or pulse counter that is off by one moves the rise or fall of the slave enable by exactly one cycle.
- A recovery condition that is wrong appears as a spurious pull-down after a held line is released.

The bench sweeps the hold time and the master side, and predicts every enable cycle by cycle from the three-edge detection latency.

// File: rtl/lr_pkg.sv
package lr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DRIVE,
        ST_PULSE,
        ST_RECOVER
    } lr_state_e;

    typedef enum logic {
        SIDE_CARD = 1'b0,
        SIDE_HOST = 1'b1
    } lr_side_e;

    typedef struct packed {
        lr_state_e state;
        lr_side_e  master;
        logic      prev_card;
        logic      prev_host;
    } lr_regs_t;

endpackage

// File: rtl/lr_sync.sv
module lr_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic meta_q, stable_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= 1'b1;
                stable_q <= 1'b1;
            end else begin
                meta_q   <= async_i[g];
                stable_q <= meta_q;
            end
        end
        assign sync_o[g] = stable_q;
    end
endmodule

// File: rtl/lr_timer.sv
module lr_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater
    import lr_pkg::*;
#(
    parameter int EDGE_DLY = 3,
    parameter int PU_LEN   = 2,
    parameter int CLK_KHZ  = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic disable_i,
    input  logic card_in_i,
    output logic card_pd_o,
    output logic card_pu_o,
    input  logic host_in_i,
    output logic host_pd_o,
    output logic host_pu_o
);
    localparam int MAX_LEN  = (EDGE_DLY > PU_LEN) ? EDGE_DLY : PU_LEN;
    localparam int CNT_W    = $clog2(MAX_LEN + 1);
    localparam int HALF_BIT = CLK_KHZ / 2000;

    if (EDGE_DLY < 1 || PU_LEN < 1) begin : g_bad_len
        $error("EDGE_DLY and PU_LEN must both be at least one cycle");
    end
    if (EDGE_DLY + PU_LEN > HALF_BIT) begin : g_bad_rate
        $error("repeat delay plus pull-up pulse exceed half a 1 MHz bit at CLK_KHZ");
    end

    logic [1:0] sync_lvl;
    logic       card_s, host_s;
    logic       card_fall, host_fall;
    logic       tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    lr_regs_t   r_d, r_q;
    logic       master_high, slave_is_card;

    lr_sync #(.WIDTH(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_in_i, card_in_i}),
        .sync_o  (sync_lvl)
    );
    assign card_s = sync_lvl[0];
    assign host_s = sync_lvl[1];

    lr_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    assign card_fall   = r_q.prev_card & ~card_s;
    assign host_fall   = r_q.prev_host & ~host_s;
    assign master_high = (r_q.master == SIDE_HOST) ? host_s : card_s;

    always_comb begin
        r_d           = r_q;
        r_d.prev_card = card_s;
        r_d.prev_host = host_s;
        tmr_load      = 1'b0;
        tmr_val       = CNT_W'(EDGE_DLY - 1);
        if (disable_i) begin
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    // host wins a tie by fixed priority
                    if (host_fall || card_fall) begin
                        r_d.master = host_fall ? SIDE_HOST : SIDE_CARD;
                        r_d.state  = ST_WAIT;
                        tmr_load   = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (master_high) begin
                        r_d.state = ST_PULSE;
                        tmr_load  = 1'b1;
                        tmr_val   = CNT_W'(PU_LEN - 1);
                    end else if (tmr_done) begin
                        r_d.state = ST_DRIVE;
                    end
                end
                ST_DRIVE: begin
                    if (master_high) begin
                        r_d.state = ST_PULSE;
                        tmr_load  = 1'b1;
                        tmr_val   = CNT_W'(PU_LEN - 1);
                    end
                end
                ST_PULSE: begin
                    if (tmr_done) r_d.state = ST_RECOVER;
                end
                ST_RECOVER: begin
                    if (card_s && host_s) r_d.state = ST_IDLE;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, master: SIDE_HOST, prev_card: 1'b1, prev_host: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign slave_is_card = (r_q.master == SIDE_HOST);
    assign card_pd_o = (r_q.state == ST_DRIVE) &  slave_is_card;
    assign host_pd_o = (r_q.state == ST_DRIVE) & ~slave_is_card;
    assign card_pu_o = (r_q.state == ST_PULSE) &  slave_is_card;
    assign host_pu_o = (r_q.state == ST_PULSE) & ~slave_is_card;
endmodule

// File: rtl/lr_checker.sv
module lr_checker (
    input logic clk,
    input logic rst_n,
    input logic disable_i,
    input logic card_pd_o,
    input logic card_pu_o,
    input logic host_pd_o,
    input logic host_pu_o
);
    assert_one_driver_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({card_pd_o, card_pu_o, host_pd_o, host_pu_o}));

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> !(card_pd_o || card_pu_o || host_pd_o || host_pu_o));

    assert_card_release_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(card_pd_o) && !$past(disable_i)) |-> card_pu_o);

    assert_host_release_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_pd_o) && !$past(disable_i)) |-> host_pu_o);

    assert_no_pulse_after_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(card_pu_o) || $rose(host_pu_o)) |-> !$past(disable_i));
endmodule

bind od_line_repeater lr_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .disable_i (disable_i),
    .card_pd_o (card_pd_o),
    .card_pu_o (card_pu_o),
    .host_pd_o (host_pd_o),
    .host_pu_o (host_pu_o)
);

// File: tb/od_line_repeater_tb.sv
module od_line_repeater_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D = 3;
    localparam int P = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dis = 1'b0;
    logic card_ext = 1'b0, host_ext = 1'b0;
    logic card_in, host_in;
    logic card_pd, card_pu, host_pd, host_pu;
    int   checks = 0, errors = 0, cycles = 0;
    bit   done = 1'b0;

    // weak-high open-drain line model
    assign card_in = !(card_ext || card_pd);
    assign host_in = !(host_ext || host_pd);

    always #(CLK_PERIOD/2) clk = ~clk;

    od_line_repeater #(.EDGE_DLY(D), .PU_LEN(P), .CLK_KHZ(16000)) dut_i (
        .clk(clk), .rst_n(rst_n), .disable_i(dis),
        .card_in_i(card_in), .card_pd_o(card_pd), .card_pu_o(card_pu),
        .host_in_i(host_in), .host_pd_o(host_pd), .host_pu_o(host_pu)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic all_zero(input string tag);
        chk(card_pd, 1'b0, tag); chk(card_pu, 1'b0, tag);
        chk(host_pd, 1'b0, tag); chk(host_pu, 1'b0, tag);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // compare slave/master enables with the latency formula at edge k
    task automatic expect_txn(input bit host_master, input int k, input int hold, input string tag);
        logic epd, epu;
        epd = (k >= 3 + D) && (k < hold + 3);
        epu = (k >= hold + 3) && (k < hold + 3 + P);
        if (host_master) begin
            chk(card_pd, epd, {tag, " R3 slave pd"});
            chk(card_pu, epu, {tag, " R5 slave pu"});
            chk(host_pd, 1'b0, {tag, " R4 master pd"});
            chk(host_pu, 1'b0, {tag, " R4 master pu"});
        end else begin
            chk(host_pd, epd, {tag, " R3 slave pd"});
            chk(host_pu, epu, {tag, " R5 slave pu"});
            chk(card_pd, 1'b0, {tag, " R4 master pd"});
            chk(card_pu, 1'b0, {tag, " R4 master pu"});
        end
    endtask

    task automatic txn(input bit host_master, input int hold, input string tag);
        @(negedge clk);
        if (host_master) host_ext = 1'b1; else card_ext = 1'b1;
        for (int k = 1; k <= hold + P + 10; k++) begin
            @(posedge clk); @(negedge clk);
            if (k < hold + 3 + P) expect_txn(host_master, k, hold, {tag, " R2"});
            else all_zero({tag, " R6 lockout after release"});
            if (k == hold) begin
                if (host_master) host_ext = 1'b0; else card_ext = 1'b0;
            end
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                report();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        all_zero("R1 in reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        all_zero("R1 after reset");

        // sweep: both master sides, hold times short and long
        for (int side = 0; side < 2; side++) begin
            for (int h = 1; h <= 12; h++) begin
                txn(side[0], h, "sweep");
            end
        end

        // R7: simultaneous fall, host wins, card is slave
        @(negedge clk);
        card_ext = 1'b1; host_ext = 1'b1;
        for (int k = 1; k <= 6 + P + 8; k++) begin
            @(posedge clk); @(negedge clk);
            if (k < 6 + 3 + P) expect_txn(1'b1, k, 6, "R7 tie");
            else all_zero("R7 tie idle");
            if (k == 6) begin card_ext = 1'b0; host_ext = 1'b0; end
        end

        // R8: card held low from inside the pulse through recovery
        @(negedge clk);
        host_ext = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            @(posedge clk); @(negedge clk);
            if (k <= 6 + 3) expect_txn(1'b1, k, 6, "R8 pre");
            else if (k < 6 + 3 + P) begin
                chk(card_pu, 1'b1, "R8 pulse continues");
                chk(card_pd, 1'b0, "R8 pulse no pd");
            end else all_zero("R8 no new master while held");
            if (k == 6) host_ext = 1'b0;
            if (k == 9) card_ext = 1'b1;
            if (k == 19) card_ext = 1'b0;
        end
        txn(1'b0, 5, "R8 recovery then new");

        // R9: disable during drive, line still low afterwards
        @(negedge clk);
        card_ext = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            @(posedge clk); @(negedge clk);
            if (k <= 3 + D + 2) expect_txn(1'b0, k, 20, "R9 pre");
            else all_zero("R9 forced idle");
            if (k == 3 + D + 2) dis = 1'b1;
            if (k == 3 + D + 5) dis = 1'b0;
            if (k == 20) card_ext = 1'b0;
        end
        txn(1'b1, 4, "R9 after disable");

        done = 1'b1;
        report();
    end
endmodule